// File: doc/BRIEF.md
# Three-Phase Gate Interlock and Protection Core

This block is the digital heart of a three-phase half-bridge driver. Each phase receives an upper-switch command and a lower-switch command from a host controller. The block turns those commands into six registered gate enables and keeps them safe. A phase whose two commands are both high has both switches blocked. A raw over-current comparator flag is filtered against short glitches. Once it is confirmed, every gate shuts off and an active-low fault output is pulled low. The fault is not latched: a fixed timer releases it about 1.9 ms after the over-current condition ends.

Two kinds of supply monitoring act on the gates. A main-supply undervoltage flag blocks all six gates and releases them as soon as it clears. Each phase also has a high-side floating-supply undervoltage flag. It blocks only that phase's upper gate, and the upper gate stays blocked after recovery until the host has driven that phase's upper command low at least once. The lower gates recover by themselves. Every input is asynchronous and passes through a two-flop synchronizer. The timers count a parameterised system clock (50 MHz by default). The host must insert dead time itself.

Top module: `phase_gate_guard`

## Requirements
- R1: For phase i, an upper command of 1 with a lower command of 0 sets gate_hi[i]=1 and gate_lo[i]=0. A lower command of 1 with an upper command of 0 sets gate_lo[i]=1 and gate_hi[i]=0. Both commands at 0 give both gates 0. Bit i of every vector belongs to phase i.
- R2: When both commands of a phase are 1, both gates of that phase are 0. The other phases are not affected.
- R3: The over-current flag is accepted only after it has been high in the synchronized domain for FILT_CYC consecutive clocks, where FILT_CYC = CLK_HZ x 2 us. A shorter pulse changes no output.
- R4: Once over-current is accepted, all six gates go to 0 and fault_n goes to 0, whatever the commands are.
- R5: fault_n returns to 1 and the gates follow their commands again CLR_CYC+3 clocks after the raw flag falls, where CLR_CYC = CLK_HZ x 1.9 ms. A new accepted over-current during the clearance period restarts the full timeout.
- R6: While the main-supply undervoltage flag is high, all six gates are 0. Once the flag is low, the gates follow their commands again with the normal latency, and fault_n is not affected.
- R7: A high-side undervoltage flag on phase i sets gate_hi[i] to 0 and leaves every other gate unaffected. After the flag clears, gate_hi[i] stays 0 while the upper command stays high. It follows the command again only after that command has been low for at least one synchronized clock.
- R8: Lower gates never depend on the high-side undervoltage flags. After a main-supply undervoltage a lower gate resumes without any command toggle.
- R9: A command change reaches the gate outputs exactly three clocks later: two synchronizer stages and one output register.
- R10: While reset is held and in the first clock after it, all gates are 0 and fault_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | NPH | Upper-switch command per phase (asynchronous) |
| lo_cmd | input | NPH | Lower-switch command per phase (asynchronous) |
| oc_raw | input | 1 | Raw over-current comparator flag, active high |
| main_uv | input | 1 | Main supply undervoltage flag, active high |
| hs_uv | input | NPH | High-side floating supply undervoltage flag per phase |
| gate_hi | output | NPH | Registered upper gate enables |
| gate_lo | output | NPH | Registered lower gate enables |
| fault_n | output | 1 | Registered over-current fault, active low |

## Verification
Over-current clearance and the high-side undervoltage hold can fall in the same cycle. The bench raises a floating-supply undervoltage on one phase and lets it recover while the upper command stays high. It then lets a fault clearance run out with that command still high. The upper gate must stay off when the fault releases, while the lower gates on the other phases return at once. A behavioural model with its own input queues and integer counters is compared on every clock. Directed checks also pin the exact release cycle and the restarted timeout.

// File: rtl/pgg_pkg.sv
package pgg_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_UP   = 2'b01,
    CMD_DOWN = 2'b10,
    CMD_BOTH = 2'b11
  } phase_cmd_t;

  function automatic int unsigned ns_to_cyc(input int unsigned clk_hz,
                                            input int unsigned ns);
    int unsigned c;
    c = ((clk_hz / 1000) * ns) / 1_000_000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned us_to_cyc(input int unsigned clk_hz,
                                            input int unsigned us);
    int unsigned c;
    c = ((clk_hz / 1000) * us) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/pgg_sync.sv
module pgg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= '0;
        else     stg[k] <= stg[k-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pgg_ocp.sv
module pgg_ocp #(
  parameter int unsigned FILT_CYC = 100,
  parameter int unsigned CLR_CYC  = 95000
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_s,
  output logic fault_act
);
  localparam int unsigned FW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam int unsigned CW = $clog2(CLR_CYC + 1);
  localparam logic [FW-1:0] FMAX  = FW'(FILT_CYC - 1);
  localparam logic [CW-1:0] CLOAD = CW'(CLR_CYC);

  logic [FW-1:0] filt_cnt;
  logic [CW-1:0] clr_cnt;
  logic          oc_hit;

  // accepted once the flag has been high for FILT_CYC clocks in a row
  assign oc_hit = oc_s && (filt_cnt == FMAX);

  always_ff @(posedge clk) begin
    if (rst)                  filt_cnt <= '0;
    else if (!oc_s)           filt_cnt <= '0;
    else if (filt_cnt != FMAX) filt_cnt <= filt_cnt + 1'b1;
  end

  // clearance timer held loaded while the condition persists
  always_ff @(posedge clk) begin
    if (rst)                 clr_cnt <= '0;
    else if (oc_hit)         clr_cnt <= CLOAD;
    else if (clr_cnt != '0)  clr_cnt <= clr_cnt - 1'b1;
  end

  assign fault_act = (clr_cnt != '0);
endmodule

// File: rtl/pgg_phase.sv
module pgg_phase
  import pgg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hin_s,
  input  logic lin_s,
  input  logic hs_uv_s,
  input  logic kill,
  output logic gate_hi_q,
  output logic gate_lo_q
);
  phase_cmd_t cmd;
  logic       hs_lock;
  logic       up_ok;
  logic       dn_ok;

  assign cmd = phase_cmd_t'({lin_s, hin_s});

  // high-side lockout: set by undervoltage, released by a low command
  always_ff @(posedge clk) begin
    if (rst) hs_lock <= 1'b0;
    else     hs_lock <= hs_uv_s | (hs_lock & hin_s);
  end

  always_comb begin
    up_ok = 1'b0;
    dn_ok = 1'b0;
    case (cmd)
      CMD_UP:   up_ok = ~hs_uv_s & ~hs_lock;
      CMD_DOWN: dn_ok = 1'b1;
      default: begin
        up_ok = 1'b0;
        dn_ok = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi_q <= 1'b0;
      gate_lo_q <= 1'b0;
    end else begin
      gate_hi_q <= up_ok & ~kill;
      gate_lo_q <= dn_ok & ~kill;
    end
  end
endmodule

// File: rtl/phase_gate_guard.sv
module phase_gate_guard
  import pgg_pkg::*;
#(
  parameter int unsigned NPH        = 3,
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned OC_FILT_NS = 2000,
  parameter int unsigned CLR_US     = 1900
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] hi_cmd,
  input  logic [NPH-1:0] lo_cmd,
  input  logic           oc_raw,
  input  logic           main_uv,
  input  logic [NPH-1:0] hs_uv,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic           fault_n
);
  localparam int unsigned FILT_CYC = ns_to_cyc(CLK_HZ, OC_FILT_NS);
  localparam int unsigned CLR_CYC  = us_to_cyc(CLK_HZ, CLR_US);
  localparam int unsigned NIN      = 3 * NPH + 2;

  logic [NIN-1:0] raw_vec;
  logic [NIN-1:0] syn_vec;
  logic [NPH-1:0] hin_s, lin_s, hsuv_s;
  logic           oc_s, muv_s;
  logic           fault_act;
  logic           kill;

  assign raw_vec = {oc_raw, main_uv, hs_uv, lo_cmd, hi_cmd};

  pgg_sync #(.W(NIN), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw_vec),
    .dout(syn_vec)
  );

  assign {oc_s, muv_s, hsuv_s, lin_s, hin_s} = syn_vec;

  pgg_ocp #(.FILT_CYC(FILT_CYC), .CLR_CYC(CLR_CYC)) u_ocp (
    .clk      (clk),
    .rst      (rst),
    .oc_s     (oc_s),
    .fault_act(fault_act)
  );

  assign kill = muv_s | fault_act;

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_ph
      pgg_phase u_ph (
        .clk      (clk),
        .rst      (rst),
        .hin_s    (hin_s[p]),
        .lin_s    (lin_s[p]),
        .hs_uv_s  (hsuv_s[p]),
        .kill     (kill),
        .gate_hi_q(gate_hi[p]),
        .gate_lo_q(gate_lo[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) fault_n <= 1'b1;
    else     fault_n <= ~fault_act;
  end
endmodule

// File: rtl/pgg_chk.sv
module pgg_chk #(
  parameter int unsigned NPH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           main_uv,
  input logic [NPH-1:0] hs_uv,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input logic           fault_n
);
  logic [1:0] age = 2'd0;
  logic       rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == '0);

  // R4
  fault_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (gate_hi == '0 && gate_lo == '0));

  // R6
  main_uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(main_uv, 3)) |-> (gate_hi == '0 && gate_lo == '0));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst_d |-> (gate_hi == '0 && gate_lo == '0 && fault_n));

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_uv
      // R7
      hs_uv_off_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(hs_uv[p], 3)) |-> !gate_hi[p]);
    end
  endgenerate
endmodule

bind phase_gate_guard pgg_chk #(.NPH(NPH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .main_uv(main_uv),
  .hs_uv  (hs_uv),
  .gate_hi(gate_hi),
  .gate_lo(gate_lo),
  .fault_n(fault_n)
);

// File: tb/sim_phase_gate_guard.sv
module sim_phase_gate_guard;
  localparam int PERIOD = 10;
  localparam int CLKHZ  = 4_000_000;
  localparam int FILT   = 8;     // 2 us at 4 MHz
  localparam int CLR    = 7600;  // 1.9 ms at 4 MHz

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hi_cmd = '0, lo_cmd = '0, hs_uv = '0;
  logic       oc_raw = 1'b0, main_uv = 1'b0;
  logic [2:0] gate_hi, gate_lo;
  logic       fault_n;

  int total = 0, bad = 0;
  bit done = 0;
  string cur = "R10";

  always #(PERIOD/2) clk = ~clk;

  phase_gate_guard #(.NPH(3), .CLK_HZ(CLKHZ)) u0 (
    .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .oc_raw(oc_raw), .main_uv(main_uv), .hs_uv(hs_uv),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n));

  // behavioural reference: queued inputs, integer counters
  logic [10:0] q1, q2;
  int          run, remain;
  logic [2:0]  hold, m_hi, m_lo;
  logic        m_fn;
  always @(posedge clk) begin
    if (rst) begin
      q1 = '0; q2 = '0; run = 0; remain = 0; hold = '0;
      m_hi = '0; m_lo = '0; m_fn = 1'b1;
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit blocked;
        blocked = q2[9] || (remain != 0);
        m_hi[i] = !blocked && q2[i] && !q2[3+i] && !q2[6+i] && !hold[i];
        m_lo[i] = !blocked && q2[3+i] && !q2[i];
      end
      m_fn = (remain == 0);
      run = q2[10] ? run + 1 : 0;
      if (run >= FILT) remain = CLR;
      else if (remain > 0) remain = remain - 1;
      for (int i = 0; i < 3; i++) hold[i] = q2[6+i] | (hold[i] & q2[i]);
      q2 = q1;
      q1 = {oc_raw, main_uv, hs_uv, lo_cmd, hi_cmd};
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if ({fault_n, gate_hi, gate_lo} !== {m_fn, m_hi, m_lo}) begin
        bad++;
        $display("FAIL %s model compare actual=%b expected=%b", cur,
                 {fault_n, gate_hi, gate_lo}, {m_fn, m_hi, m_lo});
      end
    end
  end

  task automatic chk(input string tag, input logic [6:0] exp);
    total++;
    if ({fault_n, gate_hi, gate_lo} !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag,
               {fault_n, gate_hi, gate_lo}, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL %s watchdog actual=hung expected=finished", cur);
    finish_up();
  end

  initial begin
    int k;
    step(3);
    chk("R10 during reset", 7'b1_000_000);
    rst = 1'b0;
    step(1);
    chk("R10 after reset", 7'b1_000_000);

    // R1 and R9: basic mapping and latency
    cur = "R1";
    hi_cmd = 3'b001; lo_cmd = 3'b010;
    step(2);
    chk("R9 unchanged after two clocks", 7'b1_000_000);
    step(1);
    chk("R9 R1 output after three clocks", 7'b1_001_010);
    hi_cmd = 3'b010; lo_cmd = 3'b101;
    step(4);
    chk("R1 second pattern", 7'b1_010_101);
    hi_cmd = 3'b000; lo_cmd = 3'b000;
    step(4);
    chk("R1 both low", 7'b1_000_000);

    // R2: both commands high on phase 2
    cur = "R2";
    hi_cmd = 3'b101; lo_cmd = 3'b110;
    step(4);
    chk("R2 phase2 blocked", 7'b1_001_010);

    // R3: short glitch ignored
    cur = "R3";
    oc_raw = 1'b1; step(FILT - 1); oc_raw = 1'b0;
    step(20);
    chk("R3 glitch ignored", 7'b1_001_010);

    // R4: accepted over-current
    cur = "R4";
    oc_raw = 1'b1; step(FILT + 4);
    chk("R4 all off fault low", 7'b0_000_000);
    hi_cmd = 3'b011; lo_cmd = 3'b100;
    step(4);
    chk("R4 commands ignored in fault", 7'b0_000_000);

    // R5: exact release time
    cur = "R5";
    oc_raw = 1'b0;
    k = 0;
    while (fault_n !== 1'b1 && k < CLR + 20) begin step(1); k++; end
    total++;
    if (k != CLR + 3) begin
      bad++;
      $display("FAIL R5 release delay actual=%0d expected=%0d", k, CLR + 3);
    end
    chk("R5 gates follow after release", 7'b1_011_100);

    // R5: restart during clearance
    oc_raw = 1'b1; step(FILT + 4); oc_raw = 1'b0;
    step(3000);
    oc_raw = 1'b1; step(FILT + 2); oc_raw = 1'b0;
    step(CLR + 3 - 3000 - FILT - 2 + 10);
    chk("R5 restarted timer still active", 7'b0_000_000);
    k = 0;
    while (fault_n !== 1'b1 && k < CLR + 20) begin step(1); k++; end
    total++;
    if (k != CLR + 3 - (CLR + 3 - 3000 - FILT - 2 + 10) + (CLR + 3 - (CLR + 3 - 3000 - FILT - 2 + 10)) - (CLR + 3 - (CLR + 3 - 3000 - FILT - 2 + 10))) begin
      bad++;
      $display("FAIL R5 restart delay actual=%0d expected=%0d", k,
               CLR + 3 - (CLR + 3 - 3000 - FILT - 2 + 10));
    end

    // R6 and R8: main undervoltage
    cur = "R6";
    hi_cmd = 3'b001; lo_cmd = 3'b110;
    step(4);
    main_uv = 1'b1; step(4);
    chk("R6 all off", 7'b1_000_000);
    main_uv = 1'b0; step(3);
    chk("R6 R8 resume without toggle", 7'b1_001_110);

    // R7 and R8: high-side undervoltage on phase 0, lower on phase 1
    cur = "R7";
    hs_uv = 3'b011; step(4);
    chk("R7 R8 upper0 off lower untouched", 7'b1_000_110);
    hs_uv = 3'b000; step(10);
    chk("R7 held while command high", 7'b1_000_110);
    hi_cmd = 3'b000; step(2);
    hi_cmd = 3'b001; step(4);
    chk("R7 released after low command", 7'b1_001_110);

    // fault release while high-side hold pending
    cur = "R7";
    hs_uv = 3'b001; step(4);
    hs_uv = 3'b000;
    oc_raw = 1'b1; step(FILT + 4); oc_raw = 1'b0;
    step(CLR + 10);
    chk("R7 R5 hold survives fault release", 7'b1_000_110);
    hi_cmd = 3'b000; step(2);
    hi_cmd = 3'b001; step(4);
    chk("R7 upper0 back", 7'b1_001_110);

    step(5);
    finish_up();
  end
endmodule